// File: doc/BRIEF.md
# Serial-Port Static Byte Memory

This block is a byte-wide static memory of 128 locations, or 256 as a build option. A host reaches it over a synchronous serial slave port with a clock, a data-in line and a data-out line, and it is gated by two select lines. Each transfer opens with one header byte. The header's top bit picks the direction and its lower seven bits give the starting location. Any number of data bytes follow, and the location advances after each one. Both directions shift the most significant bit first.

The block does not need to be told the host's idle clock level. It takes the serial clock level at the moment the port becomes selected as the idle level for that transfer. The first clock edge away from idle is the shift edge, on which the data-out line changes. The edge back to idle is the capture edge, on which the data-in line is sampled. All port pins are synchronised into a faster system clock, and the edges are found there. The data-out line has a separate enable. It is driven only while read data is being shifted out.

Top module: `spi_sram_slave`

## Requirements
- R1: After reset, and whenever the port is not selected, `miso_oe` is 0 and the serial logic returns to expecting a header byte.
- R2: The port is selected only while `ss_n` is 0 and `ce` is 1. Clock and data activity under any other combination leaves the memory contents unchanged.
- R3: The level of `sck` when selection begins is taken as the idle level for that transfer. Transfers work with idle low and with idle high.
- R4: Bytes move most significant bit first. In the header byte, bit 7 = 1 means write and bit 7 = 0 means read, and bits 6:0 give the starting location.
- R5: In a write, each data byte is stored at the current location when its eighth bit is captured, and the location then advances by one.
- R6: In a read, the bytes shifted out are the contents of the starting location and of each following location, one after another.
- R7: The advancing location wraps from DEPTH-1 back to 0, in both directions of transfer.
- R8: `miso_oe` is 0 during the whole of a write and during the header byte of a read. It is 1 while read data bits are shifted out.
- R9: Within one selection, only the first byte is a header. Later bytes are data, whatever their value. A new starting location needs deselection followed by reselection.
- R10: `mosi` is sampled on the capture edge (the return to idle level). `miso` changes only on the shift edge (the departure from idle level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| ss_n | input | 1 | Active-low slave select |
| ce | input | 1 | Active-high chip enable |
| miso | output | 1 | Serial read data to the host |
| miso_oe | output | 1 | High when `miso` should be driven; low means high impedance |

## Verification
The assertions assume that `sck`, `mosi` and the select lines change slowly relative to `clk`. Each level must hold for several system cycles, so the synchroniser delivers every serial edge as a separate pulse. They also assume that `sck` sits at its idle level whenever selection changes. The bench host keeps each half period of `sck` at eight system clocks. It sets the idle level and waits before it lowers `ss_n`, and it returns `sck` to idle before it deselects. The synchronised clock and data lines see the same delay, so `mosi` is always settled at a capture edge.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

  typedef enum logic {
    PH_HEADER = 1'b0,
    PH_DATA   = 1'b1
  } xfer_phase_t;

  // Location that follows cur, wrapping after last.
  function automatic logic [7:0] next_index(input logic [7:0] cur, input logic [7:0] last);
    return (cur == last) ? 8'd0 : cur + 8'd1;
  endfunction

  // Header decode: bit 7 set means write.
  function automatic logic hdr_is_write(input logic [7:0] hdr);
    return hdr[7];
  endfunction

  function automatic logic [7:0] hdr_location(input logic [7:0] hdr);
    return {1'b0, hdr[6:0]};
  endfunction

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/spi_sram_array.sv
module spi_sram_array #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];

  // R5: a stored byte is visible at its location on the next cycle
  p_store_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data)));

endmodule

// File: rtl/spi_sram_serial.sv
module spi_sram_serial
  import spi_sram_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam logic [7:0] LAST = 8'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sck,
  input  logic          mosi,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          miso,
  output logic          miso_oe
);

  logic        sel_q, sck_q, idle_hi_q, dir_wr_q, oe_q, miso_q;
  xfer_phase_t phase_q;
  logic [2:0]  bit_cnt_q;
  logic [6:0]  rx_q;
  logic [7:0]  tx_q, loc_q;

  // Named internal events
  logic       sel_rise, sck_rise, sck_fall, cap_edge, shf_edge;
  logic       byte_done, hdr_done, rd_load, out_step;
  logic [7:0] rx_byte, rd_loc;

  assign sel_rise  = sel && !sel_q;
  assign sck_rise  = sck && !sck_q;
  assign sck_fall  = !sck && sck_q;
  assign cap_edge  = sel && sel_q && (idle_hi_q ? sck_rise : sck_fall);
  assign shf_edge  = sel && sel_q && (idle_hi_q ? sck_fall : sck_rise);
  assign rx_byte   = {rx_q, mosi};
  assign byte_done = cap_edge && (bit_cnt_q == 3'd7);
  assign hdr_done  = byte_done && (phase_q == PH_HEADER);
  assign wr_en     = byte_done && (phase_q == PH_DATA) && dir_wr_q;
  assign rd_load   = byte_done && ((phase_q == PH_HEADER) ? !hdr_is_write(rx_byte) : !dir_wr_q);
  assign out_step  = shf_edge && (phase_q == PH_DATA) && !dir_wr_q;
  assign rd_loc    = (phase_q == PH_HEADER) ? hdr_location(rx_byte) : loc_q;

  assign wr_addr = loc_q[AW-1:0];
  assign wr_data = rx_byte;
  assign rd_addr = rd_loc[AW-1:0];
  assign miso    = miso_q;
  assign miso_oe = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;  sck_q <= 1'b0;  idle_hi_q <= 1'b0;
      dir_wr_q <= 1'b0;  oe_q <= 1'b0;  miso_q <= 1'b0;
      phase_q <= PH_HEADER;  bit_cnt_q <= '0;
      rx_q <= '0;  tx_q <= '0;  loc_q <= '0;
    end else begin
      sel_q <= sel;
      sck_q <= sck;
      if (!sel) begin
        phase_q   <= PH_HEADER;
        bit_cnt_q <= '0;
        dir_wr_q  <= 1'b0;
        oe_q      <= 1'b0;
        miso_q    <= 1'b0;
      end else begin
        if (sel_rise) idle_hi_q <= sck;
        if (cap_edge) begin
          rx_q      <= rx_byte[6:0];
          bit_cnt_q <= bit_cnt_q + 3'd1;
        end
        if (hdr_done) begin
          phase_q  <= PH_DATA;
          dir_wr_q <= hdr_is_write(rx_byte);
        end
        if (rd_load) begin
          tx_q  <= rd_data;
          loc_q <= next_index(rd_loc, LAST);
        end else if (hdr_done) begin
          loc_q <= hdr_location(rx_byte);
        end else if (wr_en) begin
          loc_q <= next_index(loc_q, LAST);
        end
        if (out_step) begin
          miso_q <= tx_q[7];
          tx_q   <= {tx_q[6:0], 1'b0};
          oe_q   <= 1'b1;
        end
      end
    end
  end

  // R8: output enabled only while a read is in its data phase
  p_oe_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (phase_q == PH_DATA) && !dir_wr_q);

  // R1: losing selection returns to idle state
  p_deselect_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !oe_q && (phase_q == PH_HEADER) && (bit_cnt_q == 3'd0));

  // R3: idle level is held for the whole selection
  p_idle_level_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && sel_q) |=> $stable(idle_hi_q));

  // R9: data phase persists while selected
  p_data_phase_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && phase_q == PH_DATA) |=> (phase_q == PH_DATA));

  // R7: write location wraps from the top to zero
  p_wrap_to_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && loc_q == LAST) |=> (loc_q == 8'd0));

  // R10: serial output moves only after a shift edge
  p_miso_on_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && sel_q && !shf_edge) |=> $stable(miso_q));

endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave #(
  parameter int DEPTH     = 128,
  parameter int SYNC_STGS = 2,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic ss_n,
  input  logic ce,
  output logic miso,
  output logic miso_oe
);

  logic [3:0]    pins_s;
  logic          sck_s, mosi_s, ss_n_s, ce_s, sel_s;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  spi_sram_sync #(.WIDTH(4), .STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({sck, mosi, ss_n, ce}),
    .dout  (pins_s)
  );

  assign {sck_s, mosi_s, ss_n_s, ce_s} = pins_s;
  assign sel_s = !ss_n_s && ce_s;

  spi_sram_serial #(.DEPTH(DEPTH)) u_serial (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel_s),
    .sck     (sck_s),
    .mosi    (mosi_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .miso    (miso),
    .miso_oe (miso_oe)
  );

  spi_sram_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: tb/spi_sram_slave_bench.sv
`timescale 1ns/1ps
module spi_sram_slave_bench;
  localparam int DEPTH = 128;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1, ce = 1'b0;
  logic miso, miso_oe;
  logic cur_idle = 1'b0;

  int n_checks = 0, n_fails = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  spi_sram_slave #(.DEPTH(DEPTH)) u_spi_sram_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss_n(ss_n), .ce(ce),
    .miso(miso), .miso_oe(miso_oe)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_port(input logic idle, input logic ce_lvl);
    sck = idle; cur_idle = idle; ce = ce_lvl;
    wait_clk(6);
    ss_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic close_port();
    wait_clk(4);
    ss_n = 1'b1; ce = 1'b0;
    wait_clk(6);
  endtask

  // One byte, MSB first; oe_want: 0 = must be off, 1 = must be on, 2 = ignore
  task automatic shift_byte(input logic [7:0] tx, input int oe_want, input string req,
                            output logic [7:0] rx);
    logic oe_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sck = ~cur_idle; mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      if (oe_want != 2 && miso_oe !== oe_want[0]) oe_ok = 1'b0;
      sck = cur_idle;
      wait_clk(HALF);
    end
    if (oe_want != 2) chk(oe_ok, req, int'(~oe_ok), 1);
  endtask

  function automatic logic [7:0] pattern(input int seed, input int k);
    return 8'(seed * 37 + k * 11 + 5);
  endfunction

  task automatic write_burst(input logic idle, input int start, input int seed, input int n);
    logic [7:0] rx;
    open_port(idle, 1'b1);
    shift_byte({1'b1, 7'(start)}, 0, "R8 oe off in write header", rx);
    for (int k = 0; k < n; k++) begin
      shift_byte(pattern(seed, k), 0, "R8 oe off in write data", rx);
      model[(start + k) % DEPTH] = pattern(seed, k);
    end
    close_port();
  endtask

  // Scoreboard monitor: pop expected byte and compare with received
  task automatic monitor_cmp(input logic [7:0] got, input string req);
    logic [7:0] e;
    e = exp_q.pop_front();
    chk(got === e, req, got, e);
  endtask

  task automatic read_burst(input logic idle, input int start, input int n, input string req);
    logic [7:0] rx;
    open_port(idle, 1'b1);
    shift_byte({1'b0, 7'(start)}, 0, "R8 oe off in read header", rx);
    for (int k = 0; k < n; k++) exp_q.push_back(model[(start + k) % DEPTH]);
    for (int k = 0; k < n; k++) begin
      shift_byte(8'h00, 1, "R8 oe on in read data", rx);
      monitor_cmp(rx, req);
    end
    close_port();
  endtask

  task automatic run_tests();
    logic [7:0] rx;
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hxx;
    wait_clk(5);
    chk(miso_oe === 1'b0, "R1 oe low in reset", miso_oe, 0);
    rst_n = 1'b1;
    wait_clk(5);
    chk(miso_oe === 1'b0, "R1 oe low after reset", miso_oe, 0);

    // R5 R6 R4 with idle-low clock
    write_burst(1'b0, 10, 1, 6);
    read_burst(1'b0, 10, 6, "R6 R4 read burst idle low");
    // R3 idle-high clock
    write_burst(1'b1, 40, 2, 5);
    read_burst(1'b1, 40, 5, "R3 read burst idle high");
    read_burst(1'b1, 12, 3, "R3 R10 cross-polarity read");
    // R7 wrap for write and read
    write_burst(1'b0, DEPTH - 2, 3, 4);
    read_burst(1'b1, DEPTH - 3, 5, "R7 wrap read");
    // R2 chip enable low: ignored
    open_port(1'b0, 1'b0);
    shift_byte(8'h8A, 0, "R2 oe off when ce low", rx);
    shift_byte(8'h5A, 0, "R2 oe off when ce low", rx);
    close_port();
    read_burst(1'b0, 10, 1, "R2 ce low left memory unchanged");
    // R2 slave select high: ignored
    ce = 1'b1; sck = 1'b0; cur_idle = 1'b0; wait_clk(6);
    shift_byte(8'h8B, 0, "R2 oe off when ss_n high", rx);
    shift_byte(8'hA5, 0, "R2 oe off when ss_n high", rx);
    ce = 1'b0; wait_clk(6);
    read_burst(1'b0, 11, 1, "R2 ss_n high left memory unchanged");
    // R9 header-like data bytes are stored as data
    open_port(1'b1, 1'b1);
    shift_byte(8'h80 | 8'd60, 0, "R8 oe off in write header", rx);
    shift_byte(8'h85, 0, "R8 oe off", rx);  model[60] = 8'h85;
    shift_byte(8'h05, 0, "R8 oe off", rx);  model[61] = 8'h05;
    close_port();
    read_burst(1'b0, 60, 2, "R9 later bytes are data");
    read_burst(1'b0, 5, 1, "R9 location 5 untouched");
    // R5 MSB-first single byte
    open_port(1'b0, 1'b1);
    shift_byte(8'h80 | 8'd70, 0, "R8 oe off", rx);
    shift_byte(8'h01, 0, "R8 oe off", rx);  model[70] = 8'h01;
    close_port();
    read_burst(1'b1, 70, 1, "R4 R5 msb-first single byte");
    wait_clk(4);
    chk(miso_oe === 1'b0, "R1 oe low after deselect", miso_oe, 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule